// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of up to sixteen pins, controlled from a 32-bit word bus. Each pin has a 4-bit control nibble. The low half of the nibble picks between input and output, and for outputs it also carries a speed grade that the logic does not use. The high half selects push-pull or open-drain drive. The output latch can be written as a whole word. It can also be changed bit by bit through two registers that only act on the bits written as 1: one sets or clears, the other only clears. Because of these, software never needs a read-modify-write sequence to change single pins.

Pin levels pass through a short sampling chain into the input register. A peripheral clock-enable input gates both the sampling chain and every register update. While that enable is low the port is frozen. Reads stay combinational, so the frozen state can still be read. The block drives a level and an enable for each pin; the pad that combines them lives outside.

Top module: `gpio_bank`

## Requirements
- R1: After reset both control registers read 0x44444444 (every nibble = input mode 00, floating code 01), the output latch reads 0, and every `pin_oe` and `pin_out` bit is 0.
- R2: The control register at byte offset 0x00 holds pins 0..7 and the one at 0x04 holds pins 8..15. Pin n uses nibble bits 4(n mod 8)+3..4(n mod 8); inside a nibble bits 1:0 are the mode and bits 3:2 the config. Both registers read back the full 32-bit word last written.
- R3: A write to the output latch at 0x0C loads all pin bits from data bits 15:0 in one access. Data bits 31:16 are dropped and read back as 0.
- R4: A write to the set/clear register at 0x10 sets latch bit n when data bit n is 1 and clears it when data bit 16+n is 1. Bits written as 0 leave the latch unchanged.
- R5: When one access to 0x10 has both the set bit and the clear bit of a pin at 1, the latch bit ends at 1.
- R6: A write to the clear-only register at 0x14 clears the latch bits whose data bits 15:0 are 1. Data bits 31:16 have no effect, and no bit is ever set through this register.
- R7: Reads of 0x10 and 0x14 return 0. Writes to the input register at 0x08 change no state.
- R8: While the clock enable is high, `pin_in` reaches the input register at 0x08 after exactly SYNC_STAGES clock edges (default 2). While the enable is low, the input register holds its value.
- R9: Bus writes made while the clock enable is low change neither the control registers nor the output latch.
- R10: A pin whose mode bits are 00 is an input: `pin_oe` and `pin_out` are both 0, whatever the config bits and the latch hold.
- R11: A pin with mode 01, 10 or 11 and config bit 2 of its nibble at 0 is push-pull: `pin_oe` is 1 and `pin_out` equals its latch bit, the same for all three speed codes.
- R12: A pin with mode 01, 10 or 11 and config bit 2 at 1 is open-drain: `pin_out` is 0 and `pin_oe` is the inverse of its latch bit, so the pin is pulled low for a 0 and released for a 1.
- R13: Word offsets above 0x14 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Peripheral clock enable; gates sampling and register updates |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | ADDR_W (8) | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pin_in | input | PINS (16) | Pin levels seen at the pads |
| pin_out | output | PINS (16) | Level to drive on each pin |
| pin_oe | output | PINS (16) | Drive enable for each pin |

## Verification
A corrupted output latch shows on `pin_out` or `pin_oe` on the clock edge right after the write that caused it, provided the pin is configured as an output. It also shows on a read of 0x0C in that same cycle. A control nibble decoded wrongly swaps drive kinds. That shows at once as an enable of 1 on an input pin, or as a pin driven high while it should be released. Errors in the sampling chain show as an input word that arrives one edge early or late, or that keeps changing while the clock enable is low. The bench therefore checks the edge count exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // word indices of the register window (byte offset / 4)
   localparam int unsigned WORD_CFG_LO = 0;
   localparam int unsigned WORD_CFG_HI = 1;
   localparam int unsigned WORD_IN     = 2;
   localparam int unsigned WORD_OUT    = 3;
   localparam int unsigned WORD_SETCLR = 4;
   localparam int unsigned WORD_CLR    = 5;

   localparam int unsigned NIBBLE_W    = 4;
   localparam int unsigned PINS_PER_CFG = 8;
   localparam int unsigned BUS_W       = 32;
   localparam int unsigned CLR_HALF    = 16;

   // reset nibble: config 01 (floating), mode 00 (input)
   localparam logic [NIBBLE_W-1:0] NIBBLE_RST = 4'b0100;

   typedef enum logic [1:0] {
      DRV_INPUT = 2'd0,
      DRV_PUSH  = 2'd1,
      DRV_OPEN  = 2'd2
   } drive_e;

   function automatic drive_e drive_kind(input logic [1:0] mode, input logic od_sel);
      if (mode == 2'b00)
         return DRV_INPUT;
      else if (od_sel)
         return DRV_OPEN;
      else
         return DRV_PUSH;
   endfunction

endpackage

// File: rtl/gpio_bank_sampler.sv
module gpio_bank_sampler #(
   parameter int unsigned PINS   = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clk_en,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] in_sync
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_bank_sampler: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [PINS-1:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cap_q <= '0;
            else if (clk_en)
               cap_q <= pin_in;
         end
         assign in_sync = cap_q;
      end else begin : g_chain
         logic [PINS-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++)
                  chain_q[s] <= '0;
            end else if (clk_en) begin
               chain_q[0] <= pin_in;
               for (int s = 1; s < STAGES; s++)
                  chain_q[s] <= chain_q[s-1];
            end
         end
         assign in_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS   = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [PINS-1:0]   in_sync,
   output logic [BUS_W-1:0]  rdata,
   output logic [BUS_W-1:0]  cfg_lo,
   output logic [BUS_W-1:0]  cfg_hi,
   output logic [PINS-1:0]   out_q
);

   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] A_CFG_LO = IDX_W'(WORD_CFG_LO);
   localparam logic [IDX_W-1:0] A_CFG_HI = IDX_W'(WORD_CFG_HI);
   localparam logic [IDX_W-1:0] A_IN     = IDX_W'(WORD_IN);
   localparam logic [IDX_W-1:0] A_OUT    = IDX_W'(WORD_OUT);
   localparam logic [IDX_W-1:0] A_SETCLR = IDX_W'(WORD_SETCLR);
   localparam logic [IDX_W-1:0] A_CLR    = IDX_W'(WORD_CLR);
   localparam logic [BUS_W-1:0] CFG_RST  = {PINS_PER_CFG{NIBBLE_RST}};

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("gpio_bank_regs: ADDR_W must cover six words");
      end
   endgenerate

   logic [IDX_W-1:0] word_idx;
   logic [1:0]       unused_byte_lane;
   logic             upd;
   logic [PINS-1:0]  out_d;
   logic [PINS-1:0]  set_bits;
   logic [PINS-1:0]  clr_bits;

   assign word_idx         = addr[ADDR_W-1:2];
   assign unused_byte_lane = addr[1:0];
   assign upd              = wr & clk_en;
   assign set_bits         = wdata[PINS-1:0];
   assign clr_bits         = wdata[CLR_HALF +: PINS];

   // next value of the output latch; set wins over clear in one access
   always_comb begin
      out_d = out_q;
      unique case (word_idx)
         A_OUT:    out_d = set_bits;
         A_SETCLR: out_d = (out_q & ~clr_bits) | set_bits;
         A_CLR:    out_d = out_q & ~set_bits;
         default:  out_d = out_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_lo <= CFG_RST;
         cfg_hi <= CFG_RST;
         out_q  <= '0;
      end else if (upd) begin
         if (word_idx == A_CFG_LO)
            cfg_lo <= wdata;
         if (word_idx == A_CFG_HI)
            cfg_hi <= wdata;
         out_q <= out_d;
      end
   end

   // read mux; write-only and unmapped words return zero
   always_comb begin
      rdata = '0;
      unique case (word_idx)
         A_CFG_LO: rdata = cfg_lo;
         A_CFG_HI: rdata = cfg_hi;
         A_IN:     rdata[PINS-1:0] = in_sync;
         A_OUT:    rdata[PINS-1:0] = out_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS = 16
) (
   input  logic [BUS_W-1:0] cfg_lo,
   input  logic [BUS_W-1:0] cfg_hi,
   input  logic [PINS-1:0]  out_q,
   output logic [PINS-1:0]  pin_out,
   output logic [PINS-1:0]  pin_oe
);

   logic [2*BUS_W-1:0] cfg_all;
   assign cfg_all = {cfg_hi, cfg_lo};

   generate
      for (genvar g = 0; g < PINS; g++) begin : g_pin
         logic [NIBBLE_W-1:0] nib;
         logic                unused_alt;
         drive_e              kind;

         assign nib        = cfg_all[NIBBLE_W*g +: NIBBLE_W];
         assign unused_alt = nib[3];
         assign kind       = drive_kind(nib[1:0], nib[2]);

         always_comb begin
            unique case (kind)
               DRV_PUSH: begin
                  pin_out[g] = out_q[g];
                  pin_oe[g]  = 1'b1;
               end
               DRV_OPEN: begin
                  pin_out[g] = 1'b0;
                  pin_oe[g]  = ~out_q[g];
               end
               default: begin
                  pin_out[g] = 1'b0;
                  pin_oe[g]  = 1'b0;
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS        = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);

   generate
      if (PINS < 1 || PINS > 16) begin : g_bad_pins
         $error("gpio_bank: PINS must be 1..16");
      end
   endgenerate

   logic [PINS-1:0]  in_sync;
   logic [BUS_W-1:0] cfg_lo;
   logic [BUS_W-1:0] cfg_hi;
   logic [PINS-1:0]  out_q;

   gpio_bank_sampler #(
      .PINS   (PINS),
      .STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .pin_in  (pin_in),
      .in_sync (in_sync)
   );

   gpio_bank_regs #(
      .PINS   (PINS),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .in_sync (in_sync),
      .rdata   (bus_rdata),
      .cfg_lo  (cfg_lo),
      .cfg_hi  (cfg_hi),
      .out_q   (out_q)
   );

   gpio_bank_drive #(
      .PINS (PINS)
   ) u_drive (
      .cfg_lo  (cfg_lo),
      .cfg_hi  (cfg_hi),
      .out_q   (out_q),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int unsigned PINS   = 16,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic [PINS-1:0]   out_q,
   input logic [31:0]       cfg_lo,
   input logic [31:0]       cfg_hi
);

   logic [ADDR_W-3:0] widx;
   logic              wr_go;
   logic [PINS-1:0]   lo_half;
   assign widx    = bus_addr[ADDR_W-1:2];
   assign wr_go   = bus_wr && clk_en;
   assign lo_half = bus_wdata[PINS-1:0];

   // R3
   out_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && widx == 3) |=> (out_q == $past(lo_half)));

   // R4 R5
   setclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && widx == 4) |=> ((out_q & $past(lo_half)) == $past(lo_half)));

   // R6
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && widx == 5) |=> ((out_q & $past(lo_half)) == '0));

   // R9
   gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(out_q) && $stable(cfg_lo) && $stable(cfg_hi)));

   // R7
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == 4 || widx == 5) |-> (bus_rdata == 32'h0));

   // R12
   no_undriven_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(
   .PINS   (PINS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .out_q     (out_q),
   .cfg_lo    (cfg_lo),
   .cfg_hi    (cfg_hi)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

   localparam int unsigned STG = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b1;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [15:0] pin_in = 16'h0;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_bank #(.PINS(16), .ADDR_W(8), .SYNC_STAGES(STG)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct packed {
      logic [7:0]  a;
      logic [31:0] d;
      logic [15:0] e;
   } vec_t;

   // odr expectation after each access, starting from 0
   localparam vec_t TBL [10] = '{
      '{8'h0C, 32'h0000_A5A5, 16'hA5A5},  // R3
      '{8'h10, 32'h0000_0F00, 16'hAFA5},  // R4 set
      '{8'h10, 32'h0005_0000, 16'hAFA0},  // R4 clear
      '{8'h10, 32'h4000_4000, 16'hEFA0},  // R5 set wins
      '{8'h14, 32'hFFFF_00F0, 16'hEF00},  // R6
      '{8'h10, 32'h0000_0000, 16'hEF00},  // R4 zeros
      '{8'h0C, 32'hFFFF_1234, 16'h1234},  // R3 upper dropped
      '{8'h08, 32'h0000_FFFF, 16'h1234},  // R7 input reg write ignored
      '{8'h10, 32'hFFFF_0001, 16'h0001},  // R5 all clear, one set
      '{8'h0C, 32'h0000_0000, 16'h0000}   // R3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, r); check("R1 cfg_lo", r, 32'h4444_4444);
      rd(8'h04, r); check("R1 cfg_hi", r, 32'h4444_4444);
      rd(8'h0C, r); check("R1 odr", r, 32'h0);
      check("R1 oe", {16'h0, pin_oe}, 32'h0);
      check("R1 out", {16'h0, pin_out}, 32'h0);

      // R2 readback
      wr(8'h00, 32'h89AB_CDEF); rd(8'h00, r); check("R2 lo", r, 32'h89AB_CDEF);
      wr(8'h04, 32'h1357_9BDF); rd(8'h04, r); check("R2 hi", r, 32'h1357_9BDF);

      // all push-pull 10 MHz for the table walk
      wr(8'h00, 32'h1111_1111);
      wr(8'h04, 32'h1111_1111);
      foreach (TBL[i]) begin
         wr(TBL[i].a, TBL[i].d);
         rd(8'h0C, r);
         check($sformatf("R3/R4/R5/R6/R7 vec%0d odr", i), r, {16'h0, TBL[i].e});
         check($sformatf("R11 vec%0d pin_out", i), {16'h0, pin_out}, {16'h0, TBL[i].e});
      end

      // R10 input mode ignores config and latch
      wr(8'h0C, 32'h0000_FFFF);
      wr(8'h00, 32'hC840_C840);
      wr(8'h04, 32'hC840_C840);
      check("R10 oe", {16'h0, pin_oe}, 32'h0);
      check("R10 out", {16'h0, pin_out}, 32'h0);

      // R11 push-pull, all speed codes
      wr(8'h0C, 32'h0000_5A3C);
      wr(8'h00, 32'h3213_2132);
      wr(8'h04, 32'h1321_3213);
      check("R11 oe", {16'h0, pin_oe}, 32'h0000_FFFF);
      check("R11 out", {16'h0, pin_out}, 32'h0000_5A3C);

      // R12 open drain
      wr(8'h00, 32'h7657_6576);
      wr(8'h04, 32'h5765_7657);
      check("R12 out", {16'h0, pin_out}, 32'h0);
      check("R12 oe", {16'h0, pin_oe}, 32'h0000_A5C3);

      // mixed: pins0-3 push-pull, 4-11 input, 12-15 open drain
      wr(8'h00, 32'h4444_1111);
      wr(8'h04, 32'h5555_4444);
      wr(8'h0C, 32'h0000_FFFF);
      check("R12 mixed oe hi", {16'h0, pin_oe}, 32'h0000_000F);
      check("R11 mixed out hi", {16'h0, pin_out}, 32'h0000_000F);
      wr(8'h0C, 32'h0000_0000);
      check("R12 mixed oe lo", {16'h0, pin_oe}, 32'h0000_F00F);
      check("R11 mixed out lo", {16'h0, pin_out}, 32'h0);

      // R7 write-only registers read zero
      wr(8'h10, 32'h0000_00FF);
      rd(8'h10, r); check("R7 setclr read", r, 32'h0);
      rd(8'h14, r); check("R7 clr read", r, 32'h0);

      // R8 sampling latency
      @(negedge clk);
      pin_in = 16'hBEEF;
      @(negedge clk);
      rd(8'h08, r); check("R8 one edge", r, 32'h0);
      @(negedge clk);
      rd(8'h08, r); check("R8 two edges", r, 32'h0000_BEEF);

      // R8 gated hold
      clk_en = 1'b0;
      pin_in = 16'h1111;
      repeat (5) @(negedge clk);
      rd(8'h08, r); check("R8 frozen", r, 32'h0000_BEEF);

      // R9 writes ignored while gated
      wr(8'h0C, 32'h0000_ABCD);
      wr(8'h10, 32'h0000_FFFF);
      wr(8'h00, 32'h0000_0000);
      rd(8'h0C, r); check("R9 odr", r, 32'h0000_00FF);
      rd(8'h00, r); check("R9 cfg_lo", r, 32'h4444_1111);
      clk_en = 1'b1;
      repeat (STG) @(negedge clk);
      rd(8'h08, r); check("R8 resumed", r, 32'h0000_1111);

      // R13 unmapped window
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, r); check("R13 read", r, 32'h0);
      rd(8'h0C, r); check("R13 odr kept", r, 32'h0000_00FF);
      rd(8'h04, r); check("R13 cfg_hi kept", r, 32'h5555_4444);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule